// File: doc/BRIEF.md
# Paged memory protection checker

This block guards a 512 KB local memory window in which only the lower 384 KB is backed by real storage. The window is split into 32 pages of 16 KB. Each page has a small permission register with a read enable and a write enable. Every access that arrives on the access port is checked against the permissions of the page it hits. An allowed access is forwarded to the memory port in the same cycle. A denied access never reaches the memory. It gets an error response, and its address and kind are captured in fault registers.

The storage decodes only part of the offset. Any access to the upper quarter of the window that is let through has offset bit 17 forced low. That access therefore lands on the same word as the matching offset in the 0x40000–0x5FFFF range. At reset the eight upper pages grant nothing, so this aliasing can only happen if software opens those pages or uses a debug access. Debug-tagged accesses skip the permission check completely.

Software reaches the permissions and the fault registers through a small register port. The captured fault stays until software writes a 1 to a separate clear register. A second fault that arrives before the clear only raises an overflow flag. A one-cycle pulse marks every blocked access so that an interrupt can be raised.

Top module: `page_guard`

## Requirements
- R1: The page of an access is window offset bits [18:14] (acc_addr[18:14]). A read is allowed when bit 0 of that page's permission is 1, and a write is allowed when bit 1 is 1. An allowed non-debug access drives mem_en in the same cycle, with mem_we equal to acc_write.
- R2: After reset, pages 0–23 hold permission 2'b11 and pages 24–31 hold 2'b00. The fault address and fault status read as zero, and all response outputs and fault_pulse are low.
- R3: mem_addr is the word index of the window offset (offset bits [18:2]). For offsets at or above 0x60000, offset bit 17 is cleared, so 0x60000–0x7FFFF reaches the same words as 0x40000–0x5FFFF.
- R4: A denied write leaves mem_en low and changes no stored word.
- R5: Every access gets rsp_valid one cycle later. A denied access gets rsp_err=1 and rsp_rdata=0. An allowed read gets rsp_err=0 and the word the memory returns one cycle after mem_en.
- R6: An access with acc_debug=1 is always forwarded, whether it is a read or a write and whatever the page permission is. It never raises a fault.
- R7: The first denied access captures the full 32-bit acc_addr into the fault address register (index 32). It also sets the fault status register (index 33) to valid (bit 0) and records the kind in bit 1 (1 = write).
- R8: A denied access that arrives while the status is valid sets the overflow bit (bit 2). The captured address and kind bit stay unchanged.
- R9: A write to index 34 with cfg_wdata[0]=1 clears the fault address and the fault status. A write to index 34 with cfg_wdata[0]=0 has no effect.
- R10: fault_pulse is high for exactly the cycle in which the error response of a denied access is shown. Back-to-back denied accesses give back-to-back pulses.
- R11: If a clear and a denied access fall in the same cycle, the new fault is captured fresh: valid=1, overflow=0, and the new address is stored.
- R12: A register read with cfg_write=0 returns data on cfg_rdata one cycle later, using the state before that cycle's updates. Indices 0–31 give the 2-bit permission; 32 and 33 give the fault registers; all other indices read zero. cfg_rdata is zero in any cycle that follows no read. A permission write at index 0–31 takes effect for accesses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_debug | input | 1 | Debug-tagged access, skips the permission check |
| acc_addr | input | 32 | Full byte address; bits [18:0] are the window offset |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access was denied |
| rsp_rdata | output | 32 | Read data, zero when denied |
| mem_en | output | 1 | Storage request |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | 17 | Storage word index |
| mem_wdata | output | 32 | Storage write data |
| mem_rdata | input | 32 | Storage read data, one cycle after mem_en |
| cfg_valid | input | 1 | Register port request |
| cfg_write | input | 1 | 1 = register write |
| cfg_addr | input | 6 | Register index |
| cfg_wdata | input | 2 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle later |
| fault_pulse | output | 1 | One-cycle pulse per blocked access |

## Verification
A denied access can meet a software clear of the fault registers in the same cycle. The bench drives both in one cycle, once on purpose after a fault has already been captured, and many more times in a randomized stretch. The result is judged by reading back the address and status: the new fault must be held with overflow low. A permission write can also fall in the same cycle as an access to the same page. The reference model applies the write only after the access has been judged, so the old permission must decide that access.

// File: rtl/pg_pkg.sv
package pg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Per-page access rights; bit 0 read, bit 1 write.
    typedef struct packed {
        logic wr;
        logic rd;
    } perm_t;

    // Fault status; bit 0 valid, bit 1 write, bit 2 overflow.
    typedef struct packed {
        logic ovf;
        logic is_wr;
        logic valid;
    } fstat_t;
endpackage

// File: rtl/pg_perm_file.sv
module pg_perm_file
    import pg_pkg::*;
#(
    parameter int PAGES  = 32,
    parameter int BACKED = 24,
    localparam int PG_W  = $clog2(PAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PG_W-1:0]       wr_idx,
    input  perm_t                 wr_val,
    output perm_t [PAGES-1:0]     perms
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        perm_t [PAGES-1:0] perm;
    } pf_state_t;

    pf_state_t pf_d, pf_q;

    always_comb begin
        pf_d = pf_q;
        if (wr_en) begin
            pf_d.perm[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                pf_q.perm[i] <= (i < BACKED) ? perm_t'(2'b11) : perm_t'(2'b00);
            end
        end else begin
            pf_q <= pf_d;
        end
    end

    assign perms = pf_q.perm;
endmodule

// File: rtl/pg_access_gate.sv
module pg_access_gate
    import pg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAGES     = 32,
    parameter int PAGE_BITS = 14,
    parameter int BACKED    = 24,
    localparam int PG_W     = $clog2(PAGES),
    localparam int WIN_BITS = PAGE_BITS + PG_W,
    localparam int MEM_AW   = WIN_BITS - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_debug,
    input  logic [MEM_AW-1:0]   acc_word,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  perm_t [PAGES-1:0]   perms,
    output logic                mem_en,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                deny
);
    timeunit 1ns;
    timeprecision 1ps;

    // Word-index bit that the storage drops for the reserved pages.
    localparam int ALIAS_BIT = MEM_AW - 2;

    typedef struct packed {
        logic rsp_valid;
        logic rsp_err;
        logic pass_rd;
    } gate_state_t;

    gate_state_t gt_d, gt_q;
    logic [PG_W-1:0]   page;
    logic              reserved;
    logic              allowed;
    logic [MEM_AW-1:0] mapped;

    always_comb begin
        page     = acc_word[MEM_AW-1:PAGE_BITS-2];
        reserved = (int'(page) >= BACKED);
        allowed  = acc_debug || (acc_write ? perms[page].wr : perms[page].rd);
        mapped   = acc_word;
        if (reserved) begin
            mapped[ALIAS_BIT] = 1'b0;
        end

        deny      = acc_valid && !allowed;
        mem_en    = acc_valid && allowed;
        mem_we    = acc_valid && allowed && acc_write;
        mem_addr  = mapped;
        mem_wdata = acc_wdata;

        gt_d.rsp_valid = acc_valid;
        gt_d.rsp_err   = acc_valid && !allowed;
        gt_d.pass_rd   = acc_valid && allowed && !acc_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gt_q <= '0;
        end else begin
            gt_q <= gt_d;
        end
    end

    assign rsp_valid = gt_q.rsp_valid;
    assign rsp_err   = gt_q.rsp_err;
    assign rsp_rdata = gt_q.pass_rd ? mem_rdata : '0;
endmodule

// File: rtl/pg_fault_unit.sv
module pg_fault_unit
    import pg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic              deny_wr,
    input  logic [ADDR_W-1:0] deny_addr,
    input  logic              clr,
    output logic [ADDR_W-1:0] fault_addr,
    output fstat_t            fault_stat,
    output logic              fault_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        fstat_t            stat;
        logic              pulse;
    } flt_state_t;

    flt_state_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.pulse = deny;
        // Clear acts on the old contents; a fault in the same cycle is then captured fresh.
        if (clr) begin
            fl_d.addr = '0;
            fl_d.stat = '0;
        end
        if (deny) begin
            if (!fl_d.stat.valid) begin
                fl_d.addr       = deny_addr;
                fl_d.stat.valid = 1'b1;
                fl_d.stat.is_wr = deny_wr;
            end else begin
                fl_d.stat.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign fault_addr  = fl_q.addr;
    assign fault_stat  = fl_q.stat;
    assign fault_pulse = fl_q.pulse;
endmodule

// File: rtl/page_guard.sv
module page_guard
    import pg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGES     = 32,
    parameter int PAGE_BITS = 14,
    parameter int BACKED    = 24,
    localparam int PG_W     = $clog2(PAGES),
    localparam int WIN_BITS = PAGE_BITS + PG_W,
    localparam int MEM_AW   = WIN_BITS - 2,
    localparam int CFG_AW   = $clog2(PAGES + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_debug,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               cfg_valid,
    input  logic               cfg_write,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [1:0]         cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic               fault_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CFG_AW-1:0] IDX_FADDR = CFG_AW'(PAGES);
    localparam logic [CFG_AW-1:0] IDX_FSTAT = CFG_AW'(PAGES + 1);
    localparam logic [CFG_AW-1:0] IDX_FCLR  = CFG_AW'(PAGES + 2);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    perm_t [PAGES-1:0] perms;
    logic [ADDR_W-1:0] fault_addr;
    fstat_t            fault_stat;
    logic              stat_valid;
    logic              deny;
    logic              perm_wr_en;
    logic              clr;
    logic [DATA_W-1:0] rd_mux;
    reg_state_t        rg_d, rg_q;

    always_comb begin
        perm_wr_en = cfg_valid && cfg_write && (cfg_addr < IDX_FADDR);
        clr        = cfg_valid && cfg_write && (cfg_addr == IDX_FCLR) && cfg_wdata[0];

        rd_mux = '0;
        if (cfg_addr < IDX_FADDR) begin
            rd_mux[1:0] = perms[cfg_addr[PG_W-1:0]];
        end else if (cfg_addr == IDX_FADDR) begin
            rd_mux = DATA_W'(fault_addr);
        end else if (cfg_addr == IDX_FSTAT) begin
            rd_mux = DATA_W'(fault_stat);
        end
        rg_d.rdata = (cfg_valid && !cfg_write) ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign cfg_rdata  = rg_q.rdata;
    assign stat_valid = fault_stat.valid;

    pg_perm_file #(
        .PAGES  (PAGES),
        .BACKED (BACKED)
    ) i_perm_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (perm_wr_en),
        .wr_idx (cfg_addr[PG_W-1:0]),
        .wr_val (perm_t'(cfg_wdata)),
        .perms  (perms)
    );

    pg_access_gate #(
        .DATA_W    (DATA_W),
        .PAGES     (PAGES),
        .PAGE_BITS (PAGE_BITS),
        .BACKED    (BACKED)
    ) i_access_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_debug (acc_debug),
        .acc_word  (acc_addr[WIN_BITS-1:2]),
        .acc_wdata (acc_wdata),
        .perms     (perms),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .deny      (deny)
    );

    pg_fault_unit #(
        .ADDR_W (ADDR_W)
    ) i_fault_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .deny        (deny),
        .deny_wr     (acc_write),
        .deny_addr   (acc_addr),
        .clr         (clr),
        .fault_addr  (fault_addr),
        .fault_stat  (fault_stat),
        .fault_pulse (fault_pulse)
    );
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk
    import pg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAGES     = 32,
    parameter int PAGE_BITS = 14,
    parameter int BACKED    = 24,
    localparam int PG_W     = $clog2(PAGES),
    localparam int WIN_BITS = PAGE_BITS + PG_W,
    localparam int MEM_AW   = WIN_BITS - 2,
    localparam int CFG_AW   = $clog2(PAGES + 3)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_debug,
    input logic [MEM_AW-1:0]  acc_word,
    input logic               mem_en,
    input logic               mem_we,
    input logic [MEM_AW-1:0]  mem_addr,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               fault_pulse,
    input perm_t [PAGES-1:0]  perms,
    input logic               stat_valid,
    input logic               cfg_valid,
    input logic               cfg_write,
    input logic [CFG_AW-1:0]  cfg_addr,
    input logic               clr_bit
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CFG_AW-1:0] IDX_FCLR = CFG_AW'(PAGES + 2);
    localparam logic [PG_W-1:0]   SHIFT    = PG_W'(PAGES / 4);

    logic [PG_W-1:0] pg;
    logic            rsv;
    assign pg  = acc_word[MEM_AW-1:PAGE_BITS-2];
    assign rsv = (int'(pg) >= BACKED);

    // R4
    no_denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (acc_debug || perms[pg].wr));

    // R1
    no_denied_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (acc_debug || perms[pg].rd));

    // R6
    debug_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_debug) |-> mem_en);

    // R3
    alias_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && rsv) |-> (mem_addr[MEM_AW-1:PAGE_BITS-2] == pg - SHIFT
                             && mem_addr[PAGE_BITS-3:0] == acc_word[PAGE_BITS-3:0]));

    // R3
    direct_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !rsv) |-> (mem_addr == acc_word));

    // R5
    err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R10
    pulse_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> rsp_err);

    // R10
    err_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> fault_pulse);

    // R7
    pulse_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> stat_valid);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && cfg_addr == IDX_FCLR && clr_bit) |=> (!stat_valid || fault_pulse));
endmodule

bind page_guard pg_guard_chk #(
    .DATA_W    (DATA_W),
    .PAGES     (PAGES),
    .PAGE_BITS (PAGE_BITS),
    .BACKED    (BACKED)
) i_pg_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_debug   (acc_debug),
    .acc_word    (acc_addr[WIN_BITS-1:2]),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .fault_pulse (fault_pulse),
    .perms       (perms),
    .stat_valid  (stat_valid),
    .cfg_valid   (cfg_valid),
    .cfg_write   (cfg_write),
    .cfg_addr    (cfg_addr),
    .clr_bit     (cfg_wdata[0])
);

// File: tb/test_page_guard.sv
module test_page_guard;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] BASE = 32'h8080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_debug = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic        rsp_valid, rsp_err, mem_en, mem_we, fault_pulse;
    logic [31:0] rsp_rdata, mem_wdata, cfg_rdata;
    logic [31:0] mem_rdata = '0;
    logic [16:0] mem_addr;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [1:0]  cfg_wdata = '0;

    int    n_chk = 0, n_fail = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R2";
    string e_tag = "R2";

    always #5 clk = ~clk;

    page_guard i_page_guard (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_debug(acc_debug),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fault_pulse(fault_pulse)
    );

    // Storage environment: synchronous, read data one cycle after request.
    logic [31:0] env_mem [int];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) env_mem[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= env_mem.exists(int'(mem_addr)) ? env_mem[int'(mem_addr)] : 32'h0;
        end
    end

    // Behavioural reference model.
    int          ref_perm [32];
    logic [31:0] ref_mem [int];
    logic [31:0] f_addr;
    bit          f_valid, f_wr, f_ovf;
    logic [31:0] e_rd, e_cfg;
    bit          e_rv, e_err;

    always @(posedge clk) begin
        int off, pg, key, ca;
        bit ok;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) ref_perm[i] = (i < 24) ? 3 : 0;
            f_addr = '0; f_valid = 0; f_wr = 0; f_ovf = 0;
            e_rv = 0; e_err = 0; e_rd = '0; e_cfg = '0;
        end else begin
            off = int'(acc_addr[18:0]);
            pg  = off / 16384;
            ok  = acc_debug || (acc_write ? ref_perm[pg][1] : ref_perm[pg][0]);
            key = ((off >= 'h60000) ? off - 'h20000 : off) / 4;
            e_rv  = acc_valid;
            e_err = acc_valid && !ok;
            e_rd  = '0;
            if (acc_valid && ok) begin
                if (acc_write) ref_mem[key] = acc_wdata;
                else e_rd = ref_mem.exists(key) ? ref_mem[key] : 32'h0;
            end
            ca = int'(cfg_addr);
            e_cfg = '0;
            if (cfg_valid && !cfg_write) begin
                if (ca < 32) e_cfg = 32'(ref_perm[ca]);
                else if (ca == 32) e_cfg = f_addr;
                else if (ca == 33) e_cfg = {29'd0, f_ovf, f_wr, f_valid};
            end
            if (cfg_valid && cfg_write && ca == 34 && cfg_wdata[0]) begin
                f_addr = '0; f_valid = 0; f_wr = 0; f_ovf = 0;
            end
            if (e_err) begin
                if (!f_valid) begin
                    f_valid = 1; f_wr = acc_write; f_addr = acc_addr;
                end else f_ovf = 1;
            end
            if (cfg_valid && cfg_write && ca < 32) ref_perm[ca] = int'(cfg_wdata);
        end
        e_tag = cur_req;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(e_tag, "rsp_valid",   32'(rsp_valid),   32'(e_rv));
            check(e_tag, "rsp_err",     32'(rsp_err),     32'(e_err));
            check(e_tag, "rsp_rdata",   rsp_rdata,        e_rd);
            check(e_tag, "fault_pulse", 32'(fault_pulse), 32'(e_err));
            check(e_tag, "cfg_rdata",   cfg_rdata,        e_cfg);
        end
    end

    task automatic cyc(input bit av, input bit aw, input bit ad, input logic [31:0] aa,
                       input logic [31:0] awd, input bit cv, input bit cw,
                       input int ca, input logic [1:0] cwd);
        @(negedge clk);
        acc_valid = av; acc_write = aw; acc_debug = ad; acc_addr = aa; acc_wdata = awd;
        cfg_valid = cv; cfg_write = cw; cfg_addr = 6'(ca); cfg_wdata = cwd;
    endtask

    task automatic acc(input bit w, input bit d, input logic [31:0] off, input logic [31:0] data);
        cyc(1, w, d, BASE | off, data, 0, 0, 0, 2'b00);
    endtask

    task automatic cfg(input bit w, input int idx, input logic [1:0] data);
        cyc(0, 0, 0, '0, '0, 1, w, idx, data);
    endtask

    task automatic idle();
        cyc(0, 0, 0, '0, '0, 0, 0, 0, 2'b00);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 chk_on = 1'b1;
        @(negedge clk); rst_n = 1'b1;

        // R2: reset state of permissions and fault registers
        cur_req = "R2";
        cfg(0, 0, 0); cfg(0, 23, 0); cfg(0, 24, 0); cfg(0, 31, 0);
        cfg(0, 32, 0); cfg(0, 33, 0); cfg(0, 34, 0); idle();

        // R1 and R5: allowed writes and reads in backed pages
        cur_req = "R1";
        acc(1, 0, 32'h0000_0004, 32'h1111_0001);
        acc(1, 0, 32'h0002_0010, 32'h2222_0002);
        acc(1, 0, 32'h0005_FFFC, 32'h3333_0003);
        acc(1, 0, 32'h0004_0000, 32'h4444_0004);
        cur_req = "R5";
        acc(0, 0, 32'h0000_0004, 0); acc(0, 0, 32'h0002_0010, 0);
        acc(0, 0, 32'h0005_FFFC, 0); acc(0, 0, 32'h0000_0100, 0); idle();

        // R4: denied write into reserved page, aliased word unchanged
        cur_req = "R4";
        acc(1, 0, 32'h0006_0000, 32'hDEAD_BEEF);
        acc(0, 0, 32'h0004_0000, 0); idle();
        // R7: captured address and write kind
        cur_req = "R7";
        cfg(0, 32, 0); cfg(0, 33, 0); idle();
        // R8: second fault sets overflow, keeps first capture
        cur_req = "R8";
        acc(0, 0, 32'h0007_FFF0, 0); cfg(0, 32, 0); cfg(0, 33, 0); idle();
        // R9: clear with bit 0 low is ignored, then a real clear
        cur_req = "R9";
        cfg(1, 34, 2'b10); cfg(0, 33, 0); cfg(0, 32, 0);
        cfg(1, 34, 2'b01); cfg(0, 33, 0); cfg(0, 32, 0); idle();

        // R6: debug accesses bypass the closed pages
        cur_req = "R6";
        acc(1, 1, 32'h0006_4000, 32'h5555_0005);
        acc(0, 0, 32'h0004_4000, 0);
        acc(0, 1, 32'h0006_4000, 0);
        cfg(0, 33, 0); idle();

        // R3: open a reserved page and observe the aliasing
        cur_req = "R3";
        cfg(1, 24, 2'b11);
        acc(1, 0, 32'h0006_8008, 32'h6666_0006);
        acc(0, 0, 32'h0004_8008, 0);
        acc(1, 0, 32'h0004_000C, 32'h7777_0007);
        acc(0, 0, 32'h0006_000C, 0); idle();

        // R12: permission write then read-back, effect on next access
        cur_req = "R12";
        cfg(1, 5, 2'b01); cfg(0, 5, 0);
        acc(1, 0, 32'h0001_4000, 32'h8888_0008);
        acc(0, 0, 32'h0001_4000, 0);
        cfg(1, 6, 2'b10); acc(0, 0, 32'h0001_8000, 0);
        cfg(0, 35, 0); cfg(0, 63, 0); idle();

        // R10: back-to-back denied accesses pulse twice
        cur_req = "R10";
        cfg(1, 34, 2'b01);
        acc(1, 0, 32'h0007_0000, 32'h1);
        acc(0, 0, 32'h0007_4000, 0);
        idle(); cfg(0, 33, 0); idle();

        // R11: clear and new fault in the same cycle
        cur_req = "R11";
        cyc(1, 0, 0, 32'hABC7_C010, 0, 1, 1, 34, 2'b01);
        cfg(0, 32, 0); cfg(0, 33, 0); idle();

        // Mixed traffic across all pages and register operations
        cur_req = "R1";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] off;
            int op;
            off = ($urandom_range(0, 31) << 14) | ($urandom_range(0, 7) << 2);
            op  = int'($urandom_range(0, 9));
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 7) == 0,
                {$urandom_range(0, 8191) << 19} | off, $urandom(),
                op < 6, op < 3,
                (op == 0) ? int'($urandom_range(0, 31)) :
                (op < 3) ? 34 : int'($urandom_range(0, 36)),
                2'($urandom_range(0, 3)));
        end
        idle(); idle(); idle();
        finish_run();
    end
endmodule